// File: doc/BRIEF.md
# Rename History Buffer With Rollback

This block keeps, for one hardware thread, the ordered record of every destination-register rename a register renamer has made. Each rename pushes one entry at the young end. The entry holds the instruction's sequence number, the architectural register it wrote, the physical register that held that architectural register before, and the physical register just allocated to it. The map table, the free list and the ready scoreboard are outside the block. The block changes them only through three write ports.

When instructions commit, the commit stage presents a done sequence number. The block then drops entries from the old end without touching the map, because those mappings are now permanent. When the pipeline squashes, the block walks back from the youngest entry, one entry per cycle. For each entry it undoes, it puts the old mapping back in the map table and returns the freshly allocated register to the free list. A full flush walks back every entry. A squash stops at the first entry that is not younger than the squash sequence number. Physical indices at or above the count of real physical registers are special registers, and undoing one of them also marks it ready in the scoreboard. A machine with several threads uses one instance per thread.

Top module: `rename_history_buf`

## Requirements
- R1: A push (`push_valid`=1) is accepted when the buffer is not full, `busy` is low, and neither `squash_req` nor `flush_req` is high. An accepted push stores its sequence number, architectural register, previous physical register and new physical register as the youngest entry.
- R2: `full` is high exactly when DEPTH entries are held. A push while `full` is high is refused and adds no entry.
- R3: A commit takes effect when `done_seq` is nonzero, `done_is_squash` is 0, `busy` is low and no squash or flush is requested. It removes entries from the oldest end whose sequence number is less than or equal to `done_seq`, at most RETIRE_W of them per cycle, and it stops at the first entry whose sequence number is greater. It makes no map, free-list or scoreboard write. `committed_cnt` rises by the number removed on the next cycle.
- R4: A `done_seq` of zero, or a commit with `done_is_squash`=1, removes nothing.
- R5: A squash or flush request seen while `busy` is low drives `busy` high from the next cycle. On each following edge, the youngest entry is undone if one exists and, for a squash, if its sequence number is greater than `squash_seq`. On the first edge where no entry qualifies, `busy` drops. `undone_cnt` counts the entries undone.
- R6: Each undo drives, in the same cycle and one cycle after its edge, `map_we` with `map_areg`/`map_preg` set to the entry's architectural and previous physical register, and `free_we` with `free_preg` set to the entry's new physical register.
- R7: When an undone entry's new physical register is at or above NUM_PHYS, `ready_we` is also high in that cycle, with `ready_preg` set to that register. Otherwise `ready_we` stays low.
- R8: A flush undoes every entry, regardless of sequence numbers.
- R9: While `busy` is high, pushes, commits and new squash or flush requests are ignored.
- R10: A squash or flush request takes priority over a push and a commit presented in the same cycle; both are dropped. When both requests are high, the flush behaviour applies.
- R11: After a synchronous active-low reset the buffer is empty, `full` and `busy` are low, all write enables are low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Rename record offered this cycle |
| push_seq | input | SEQ_W | Sequence number of the renamed instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_prev | input | PREG_W | Physical register mapped before the rename |
| push_new | input | PREG_W | Physical register allocated by the rename |
| done_seq | input | SEQ_W | Commit progress; zero means no commit |
| done_is_squash | input | 1 | Commit information belongs to a squash; blocks retirement |
| squash_req | input | 1 | Start a rollback down to `squash_seq` |
| squash_seq | input | SEQ_W | Entries with a greater sequence number are undone |
| flush_req | input | 1 | Start a rollback of every entry |
| full | output | 1 | DEPTH entries held |
| busy | output | 1 | Rollback in progress |
| map_we | output | 1 | Map-table restore write |
| map_areg | output | AREG_W | Architectural register being restored |
| map_preg | output | PREG_W | Physical register written back into the map |
| free_we | output | 1 | Free-list return write |
| free_preg | output | PREG_W | Physical register returned |
| ready_we | output | 1 | Scoreboard set-ready write for special registers |
| ready_preg | output | PREG_W | Register marked ready |
| committed_cnt | output | STAT_W | Entries retired by commit since reset |
| undone_cnt | output | STAT_W | Entries undone by rollback since reset |

## Verification
Every result lands exactly one clock edge after the input that causes it. Pushes and commits show in `full` and `committed_cnt` one cycle after they are presented. A squash or flush raises `busy` one cycle later, and each undo's map, free-list and scoreboard writes show one cycle after the edge that pops that entry. The final undo is followed by one more cycle with `busy` still high before it falls. The bench drives inputs on the falling edge and advances its queue-based reference model by one step for each step the design takes. It compares every output at the next falling edge, so a result that comes early or late by one cycle shows up as a mismatch.

// File: rtl/rhb_pkg.sv
// Shared definitions for the rename history buffer.
// Assumes: pointer arithmetic is done on indices smaller than the ring depth.
package rhb_pkg;

    // Rollback walker state
    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_WALK = 1'b1
    } rb_state_e;

    // Advance a ring index by step slots, wrapping at depth (step <= depth)
    function automatic int ring_wrap(input int idx, input int step, input int depth);
        int sum;
        sum = idx + step;
        if (sum >= depth) sum = sum - depth;
        return sum;
    endfunction

endpackage

// File: rtl/rhb_ring.sv
// Circular store of rename records, oldest at head, youngest just below tail.
// Supports one push at the young end, popping up to RETIRE_W records from the
// old end, or popping the youngest record, all in one cycle.
// Assumes: the controller never pops more than it holds, never pushes while
// full, and never pops both ends in the same cycle.
module rhb_ring
    import rhb_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 16,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int RETIRE_W = 2,
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NPOP_W  = $clog2(RETIRE_W + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push_en,
    input  logic [SEQ_W-1:0]                   push_seq,
    input  logic [AREG_W-1:0]                  push_areg,
    input  logic [PREG_W-1:0]                  push_prev,
    input  logic [PREG_W-1:0]                  push_new,
    input  logic [NPOP_W-1:0]                  head_pop_n,
    input  logic                               tail_pop,
    output logic [CNT_W-1:0]                   count,
    output logic [RETIRE_W-1:0][SEQ_W-1:0]     head_seq,
    output logic [SEQ_W-1:0]                   tail_seq,
    output logic [AREG_W-1:0]                  tail_areg,
    output logic [PREG_W-1:0]                  tail_prev,
    output logic [PREG_W-1:0]                  tail_new
);

    logic [SEQ_W-1:0]  seq_mem  [DEPTH];
    logic [AREG_W-1:0] areg_mem [DEPTH];
    logic [PREG_W-1:0] prev_mem [DEPTH];
    logic [PREG_W-1:0] new_mem  [DEPTH];

    logic [PTR_W-1:0] head_ptr;
    logic [PTR_W-1:0] tail_ptr;
    logic [PTR_W-1:0] tail_next;
    logic [PTR_W-1:0] youngest_idx;

    assign tail_next    = PTR_W'(ring_wrap(int'(tail_ptr), 1, DEPTH));
    assign youngest_idx = PTR_W'(ring_wrap(int'(tail_ptr), DEPTH - 1, DEPTH));

    // Write an accepted record into the slot at the tail
    always_ff @(posedge clk) begin
        if (push_en) begin
            seq_mem[tail_ptr]  <= push_seq;
            areg_mem[tail_ptr] <= push_areg;
            prev_mem[tail_ptr] <= push_prev;
            new_mem[tail_ptr]  <= push_new;
        end
    end

    // Move head, tail and occupancy for the operations of this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            head_ptr <= PTR_W'(ring_wrap(int'(head_ptr), int'(head_pop_n), DEPTH));
            if (push_en)       tail_ptr <= tail_next;
            else if (tail_pop) tail_ptr <= youngest_idx;
            count <= count - CNT_W'(head_pop_n) + CNT_W'(push_en) - CNT_W'(tail_pop);
        end
    end

    // Expose the RETIRE_W oldest sequence numbers for the commit selector
    for (genvar i = 0; i < RETIRE_W; i++) begin : g_head_view
        logic [PTR_W-1:0] slot;
        assign slot        = PTR_W'(ring_wrap(int'(head_ptr), i, DEPTH));
        assign head_seq[i] = seq_mem[slot];
    end

    // Expose the youngest record for the rollback walker
    assign tail_seq  = seq_mem[youngest_idx];
    assign tail_areg = areg_mem[youngest_idx];
    assign tail_prev = prev_mem[youngest_idx];
    assign tail_new  = new_mem[youngest_idx];

    // R2
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !push_en);
    // R5
    no_tail_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_pop |-> (count != '0));
    // R3
    no_head_overpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(head_pop_n) <= count);
    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/rhb_retire_sel.sv
// Decides how many of the oldest records a commit may retire this cycle:
// the longest run from the head, capped at RETIRE_W, whose sequence numbers
// are not above the done sequence number.
// Assumes: sequence numbers do not wrap within the buffer's lifetime.
module rhb_retire_sel #(
    parameter int SEQ_W    = 16,
    parameter int RETIRE_W = 2,
    parameter int CNT_W    = 4,
    localparam int NPOP_W  = $clog2(RETIRE_W + 1)
) (
    input  logic                           enable,
    input  logic [CNT_W-1:0]               count,
    input  logic [RETIRE_W-1:0][SEQ_W-1:0] head_seq,
    input  logic [SEQ_W-1:0]               done_seq,
    output logic [NPOP_W-1:0]              pop_n
);

    logic [RETIRE_W-1:0] eligible;

    // Flag each head-side slot that holds a record old enough to retire
    for (genvar i = 0; i < RETIRE_W; i++) begin : g_elig
        assign eligible[i] = (CNT_W'(i) < count) && (head_seq[i] <= done_seq);
    end

    // Count the unbroken run of eligible slots starting at the head
    always_comb begin
        logic run;
        run   = enable;
        pop_n = '0;
        for (int i = 0; i < RETIRE_W; i++) begin
            if (run && eligible[i]) pop_n = NPOP_W'(i + 1);
            else                    run   = 1'b0;
        end
    end

endmodule

// File: rtl/rhb_rollback.sv
// Rollback walker: after a squash or flush request it pops the youngest record
// once per cycle while that record qualifies, and issues the matching map
// restore, free-list return and, for special registers, scoreboard ready write.
// Assumes: the ring holds records in age order and reports whether it is empty.
module rhb_rollback
    import rhb_pkg::*;
#(
    parameter int SEQ_W    = 16,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int NUM_PHYS = 96,
    parameter int STAT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              squash_req,
    input  logic              flush_req,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              entry_avail,
    input  logic [SEQ_W-1:0]  tail_seq,
    input  logic [AREG_W-1:0] tail_areg,
    input  logic [PREG_W-1:0] tail_prev,
    input  logic [PREG_W-1:0] tail_new,
    output logic              busy,
    output logic              tail_pop,
    output logic              map_we,
    output logic [AREG_W-1:0] map_areg,
    output logic [PREG_W-1:0] map_preg,
    output logic              free_we,
    output logic [PREG_W-1:0] free_preg,
    output logic              ready_we,
    output logic [PREG_W-1:0] ready_preg,
    output logic [STAT_W-1:0] undone_cnt
);

    localparam logic [PREG_W:0] SPECIAL_BASE = (PREG_W + 1)'(NUM_PHYS);

    rb_state_e        state;
    logic             flush_mode;
    logic [SEQ_W-1:0] seq_limit;
    logic             is_special;

    assign busy       = (state == RB_WALK);
    assign tail_pop   = busy && entry_avail && (flush_mode || (tail_seq > seq_limit));
    assign is_special = ({1'b0, tail_new} >= SPECIAL_BASE);

    // Enter the walk on a request, leave it once no record qualifies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RB_IDLE;
            flush_mode <= 1'b0;
            seq_limit  <= '0;
        end else begin
            unique case (state)
                RB_IDLE: if (squash_req || flush_req) begin
                    state      <= RB_WALK;
                    flush_mode <= flush_req;
                    seq_limit  <= squash_seq;
                end
                RB_WALK: if (!tail_pop) state <= RB_IDLE;
                default: state <= RB_IDLE;
            endcase
        end
    end

    // Register the restore, return and ready writes for each undone record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_we     <= 1'b0;
            map_areg   <= '0;
            map_preg   <= '0;
            free_we    <= 1'b0;
            free_preg  <= '0;
            ready_we   <= 1'b0;
            ready_preg <= '0;
            undone_cnt <= '0;
        end else begin
            map_we   <= tail_pop;
            free_we  <= tail_pop;
            ready_we <= tail_pop && is_special;
            if (tail_pop) begin
                map_areg   <= tail_areg;
                map_preg   <= tail_prev;
                free_preg  <= tail_new;
                ready_preg <= tail_new;
                undone_cnt <= undone_cnt + 1'b1;
            end
        end
    end

    // R5
    walk_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(squash_req || flush_req));
    // R6
    restore_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> $past(busy));
    // R5
    undo_counts_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> (undone_cnt == $past(undone_cnt) + 1'b1));

endmodule

// File: rtl/rename_history_buf.sv
// Per-thread rename history buffer. Records each destination rename, retires
// records in age order on commit, and rolls back younger records on a squash
// or all records on a flush, driving the external map, free list and
// scoreboard through write ports.
// Assumes: sequence numbers rise monotonically and do not wrap while held.
module rename_history_buf #(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 16,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int NUM_PHYS = 96,
    parameter int RETIRE_W = 2,
    parameter int STAT_W   = 16,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NPOP_W  = $clog2(RETIRE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_prev,
    input  logic [PREG_W-1:0] push_new,
    input  logic [SEQ_W-1:0]  done_seq,
    input  logic              done_is_squash,
    input  logic              squash_req,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_req,
    output logic              full,
    output logic              busy,
    output logic              map_we,
    output logic [AREG_W-1:0] map_areg,
    output logic [PREG_W-1:0] map_preg,
    output logic              free_we,
    output logic [PREG_W-1:0] free_preg,
    output logic              ready_we,
    output logic [PREG_W-1:0] ready_preg,
    output logic [STAT_W-1:0] committed_cnt,
    output logic [STAT_W-1:0] undone_cnt
);

    logic [CNT_W-1:0]               occ;
    logic [RETIRE_W-1:0][SEQ_W-1:0] head_seq;
    logic [SEQ_W-1:0]               tail_seq;
    logic [AREG_W-1:0]              tail_areg;
    logic [PREG_W-1:0]              tail_prev;
    logic [PREG_W-1:0]              tail_new;
    logic                           tail_pop;
    logic [NPOP_W-1:0]              pop_n;
    logic                           push_en;
    logic                           commit_en;
    logic                           req_any;

    assign req_any   = squash_req || flush_req;
    assign full      = (occ == CNT_W'(DEPTH));
    assign push_en   = push_valid && !full && !busy && !req_any;
    assign commit_en = (done_seq != '0) && !done_is_squash && !busy && !req_any;

    rhb_ring #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
        .PREG_W(PREG_W), .RETIRE_W(RETIRE_W)
    ) ring_i (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_seq(push_seq), .push_areg(push_areg),
        .push_prev(push_prev), .push_new(push_new),
        .head_pop_n(pop_n), .tail_pop(tail_pop),
        .count(occ), .head_seq(head_seq),
        .tail_seq(tail_seq), .tail_areg(tail_areg),
        .tail_prev(tail_prev), .tail_new(tail_new)
    );

    rhb_retire_sel #(
        .SEQ_W(SEQ_W), .RETIRE_W(RETIRE_W), .CNT_W(CNT_W)
    ) retire_i (
        .enable(commit_en), .count(occ), .head_seq(head_seq),
        .done_seq(done_seq), .pop_n(pop_n)
    );

    rhb_rollback #(
        .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
        .NUM_PHYS(NUM_PHYS), .STAT_W(STAT_W)
    ) walk_i (
        .clk(clk), .rst_n(rst_n),
        .squash_req(squash_req), .flush_req(flush_req), .squash_seq(squash_seq),
        .entry_avail(occ != '0),
        .tail_seq(tail_seq), .tail_areg(tail_areg),
        .tail_prev(tail_prev), .tail_new(tail_new),
        .busy(busy), .tail_pop(tail_pop),
        .map_we(map_we), .map_areg(map_areg), .map_preg(map_preg),
        .free_we(free_we), .free_preg(free_preg),
        .ready_we(ready_we), .ready_preg(ready_preg),
        .undone_cnt(undone_cnt)
    );

    // Accumulate the number of records retired by commit
    always_ff @(posedge clk) begin
        if (!rst_n) committed_cnt <= '0;
        else        committed_cnt <= committed_cnt + STAT_W'(pop_n);
    end

    // R9
    no_retire_while_walking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pop_n == '0));
    // R9
    no_push_while_walking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push_en);
    // R4
    zero_done_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_seq == '0 || done_is_squash) |-> (pop_n == '0));

endmodule

// File: tb/rename_history_buf_tb.sv
// Bench: queue-based reference model stepped once per clock, every output
// compared at each falling edge.
module rename_history_buf_tb_top;

    localparam int DEPTH    = 8;
    localparam int SEQ_W    = 16;
    localparam int AREG_W   = 5;
    localparam int PREG_W   = 7;
    localparam int NUM_PHYS = 96;
    localparam int RETIRE_W = 2;
    localparam int STAT_W   = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    logic              rst_n;
    logic              push_valid;
    logic [SEQ_W-1:0]  push_seq;
    logic [AREG_W-1:0] push_areg;
    logic [PREG_W-1:0] push_prev;
    logic [PREG_W-1:0] push_new;
    logic [SEQ_W-1:0]  done_seq;
    logic              done_is_squash;
    logic              squash_req;
    logic [SEQ_W-1:0]  squash_seq;
    logic              flush_req;
    logic              full, busy, map_we, free_we, ready_we;
    logic [AREG_W-1:0] map_areg;
    logic [PREG_W-1:0] map_preg, free_preg, ready_preg;
    logic [STAT_W-1:0] committed_cnt, undone_cnt;

    rename_history_buf #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
        .NUM_PHYS(NUM_PHYS), .RETIRE_W(RETIRE_W), .STAT_W(STAT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
        .push_prev(push_prev), .push_new(push_new),
        .done_seq(done_seq), .done_is_squash(done_is_squash),
        .squash_req(squash_req), .squash_seq(squash_seq), .flush_req(flush_req),
        .full(full), .busy(busy),
        .map_we(map_we), .map_areg(map_areg), .map_preg(map_preg),
        .free_we(free_we), .free_preg(free_preg),
        .ready_we(ready_we), .ready_preg(ready_preg),
        .committed_cnt(committed_cnt), .undone_cnt(undone_cnt)
    );

    typedef struct {
        int seq;
        int areg;
        int prv;
        int nw;
    } rec_t;

    rec_t q[$];
    bit   m_busy, m_flush;
    int   m_lim;
    bit   e_map_we, e_free_we, e_ready_we;
    int   e_areg, e_prev, e_new;
    int   e_comm, e_undo;
    int   n_chk, n_fail;
    int   next_seq;
    bit   finished;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock of the reference model, using the inputs now on the pins
    task automatic model_step();
        e_map_we = 0; e_free_we = 0; e_ready_we = 0;
        if (m_busy) begin
            if (q.size() > 0 && (m_flush || q[q.size()-1].seq > m_lim)) begin
                rec_t r;
                r = q.pop_back();
                e_map_we = 1; e_free_we = 1;
                e_ready_we = (r.nw >= NUM_PHYS);
                e_areg = r.areg; e_prev = r.prv; e_new = r.nw;
                e_undo++;
            end else begin
                m_busy = 0;
            end
        end else if (squash_req || flush_req) begin
            m_busy = 1; m_flush = flush_req; m_lim = int'(squash_seq);
        end else begin
            int sz;
            sz = q.size();
            if (done_seq != 0 && !done_is_squash) begin
                int n;
                n = 0;
                while (n < RETIRE_W && q.size() > 0 && q[0].seq <= int'(done_seq)) begin
                    void'(q.pop_front());
                    n++;
                    e_comm++;
                end
            end
            if (push_valid && sz < DEPTH)
                q.push_back('{int'(push_seq), int'(push_areg), int'(push_prev), int'(push_new)});
        end
    endtask

    task automatic compare();
        chk("R5 busy", int'(busy), int'(m_busy));
        chk("R2 full", int'(full), int'(q.size() == DEPTH));
        chk("R6 map_we", int'(map_we), int'(e_map_we));
        chk("R6 free_we", int'(free_we), int'(e_free_we));
        chk("R7 ready_we", int'(ready_we), int'(e_ready_we));
        if (e_map_we) begin
            chk("R6 map_areg", int'(map_areg), e_areg);
            chk("R6 map_preg", int'(map_preg), e_prev);
            chk("R6 free_preg", int'(free_preg), e_new);
        end
        if (e_ready_we) chk("R7 ready_preg", int'(ready_preg), e_new);
        chk("R3 committed_cnt", int'(committed_cnt), e_comm);
        chk("R5 undone_cnt", int'(undone_cnt), e_undo);
    endtask

    task automatic idle_inputs();
        push_valid = 0; push_seq = '0; push_areg = '0; push_prev = '0; push_new = '0;
        done_seq = '0; done_is_squash = 0;
        squash_req = 0; squash_seq = '0; flush_req = 0;
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic set_push(input int areg, input int prv, input int nw);
        push_valid = 1;
        push_seq   = SEQ_W'(next_seq);
        next_seq++;
        push_areg  = AREG_W'(areg);
        push_prev  = PREG_W'(prv);
        push_new   = PREG_W'(nw);
    endtask

    task automatic drain_walk();
        while (m_busy) tick();
    endtask

    initial begin
        n_chk = 0; n_fail = 0; next_seq = 1; finished = 0;
        e_comm = 0; e_undo = 0; m_busy = 0; m_flush = 0; m_lim = 0;
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R11: reset state
        compare();
        rst_n = 1;

        // R1, R2: fill past capacity; the ninth push is refused
        for (int i = 0; i < DEPTH + 1; i++) begin
            set_push(i, 10 + i, 40 + i);
            tick();
        end

        // R4: zero done number and squash-flagged commit retire nothing
        done_seq = SEQ_W'(100); done_is_squash = 1; tick();
        done_seq = '0; tick();

        // R3: retire three oldest, two per cycle at most
        for (int i = 0; i < 3; i++) begin
            done_seq = SEQ_W'(3);
            tick();
        end

        // R5, R6, R9: squash to seq 5, with pushes and commits ignored while busy
        squash_req = 1; squash_seq = SEQ_W'(5); tick();
        for (int i = 0; i < 3; i++) begin
            set_push(2, 3, 4); done_seq = SEQ_W'(50); squash_req = 1; squash_seq = '0;
            tick();
        end
        drain_walk();
        tick();

        // R7, R8: special registers then flush everything
        set_push(7, 20, NUM_PHYS); tick();
        set_push(8, 21, 127); tick();
        set_push(9, 22, NUM_PHYS - 1); tick();
        flush_req = 1; tick();
        drain_walk();
        tick();

        // R10: request beats push and commit in the same cycle; flush beats squash
        set_push(1, 2, 3); tick();
        set_push(4, 5, 6); tick();
        set_push(7, 8, 9); done_seq = SEQ_W'(next_seq); squash_req = 1;
        squash_seq = SEQ_W'(next_seq); tick();
        drain_walk();
        squash_req = 1; squash_seq = SEQ_W'(next_seq); flush_req = 1; tick();
        drain_walk();
        tick();

        // Mixed traffic
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 55) set_push(int'($urandom % 32), int'($urandom % 128), int'($urandom % 128));
            if (r >= 35 && r < 80) begin
                int d;
                d = next_seq - int'($urandom % 8);
                done_seq = SEQ_W'((d < 0) ? 0 : d);
                done_is_squash = ($urandom % 10 == 0);
            end
            if (r >= 95 && r < 99) begin
                int s;
                s = next_seq - 1 - int'($urandom % 6);
                squash_req = 1;
                squash_seq = SEQ_W'((s < 0) ? 0 : s);
            end
            if (r == 99) flush_req = 1;
            tick();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (R5 rollback completion): actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule